// File: doc/BRIEF.md
# Timestamp-Ordered Sparse Hit Readout

This block collects hits from a small pixel matrix and streams them out as address words. A free-running timestamp counter advances once every `TICK_DIV` clock cycles. When a pixel fires, its own slot stores the timestamp that is current at that moment. A sorting selector then always presents the stored hit with the oldest timestamp. Ties are broken by position: the lowest row goes first, then the lowest column. Each output word carries the row, the column and the stored timestamp, and it leaves through a valid/ready handshake.

Two readout modes are available. In push mode every hit is delivered, but only once its timestamp period has closed. This ensures that all hits sharing a timestamp are known before any of them leaves. In triggered mode, a trigger strobe selects the timestamp that was current `LATENCY` ticks earlier. Only hits stored with that timestamp are delivered. A hit that passes the latency window without being triggered is dropped, and its pixel is freed. Each pixel slot holds a single hit, so a second hit on an occupied pixel is lost; this is the pixel's dead time.

Top module: `ts_sorted_readout`

## Requirements
- R1: A synchronous active-high reset empties every pixel slot and zeroes the timestamp and the prescaler, so `out_valid_o` is low after reset.
- R2: The timestamp starts at 0 after reset and rises by one every `TICK_DIV` (5) cycles. It wraps modulo 2^`TS_W` (256), and hits stored on both sides of a wrap still leave oldest first.
- R3: A rising hit on `hit_i[r*COLS+c]` stores the timestamp current at that clock edge. It is later delivered as `out_row_o`=r, `out_col_o`=c, `out_ts_o`=stored timestamp.
- R4: Words leave in order of age, measured as the current timestamp minus the stored timestamp modulo 2^`TS_W`. No word is older than one delivered before it.
- R5: Among hits with the same timestamp, the lowest row leaves first, and within a row the lowest column leaves first.
- R6: In push mode (`trig_mode_i`=0), a hit is not presented while its own timestamp is still the current one.
- R7: While `out_valid_o` is high and `out_ready_i` is low, valid stays high and row, column and timestamp hold steady. A pixel is freed on the cycle its word is taken (valid and ready both high).
- R8: A hit on a pixel that already holds a stored hit is dropped, and the stored one is kept.
- R9: In push mode every stored hit is delivered exactly once.
- R10: In triggered mode (`trig_mode_i`=1), a hit is delivered only if a trigger strobe arrived while its stored timestamp equalled the current timestamp minus `LATENCY` (60).
- R11: In triggered mode, a stored hit whose age exceeds `LATENCY` without a matching trigger is discarded, and its pixel accepts new hits again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | ROWS*COLS | Per-pixel hit strobes, bit r*COLS+c for row r, column c |
| trig_i | input | 1 | Trigger strobe, selects timestamp now minus LATENCY |
| trig_mode_i | input | 1 | 0 = push mode, 1 = triggered mode |
| out_ready_i | input | 1 | Downstream accepts a word |
| out_valid_o | output | 1 | A word is presented |
| out_row_o | output | RW | Row index of the presented hit |
| out_col_o | output | CW | Column index of the presented hit |
| out_ts_o | output | TS_W | Stored timestamp of the presented hit |

## Verification
A hit strobe driven before clock edge n is stored with timestamp floor((n-1)/5) counted from the first edge after reset. In push mode it can appear only after the edge where the timestamp next advances. An armed hit appears the cycle after its trigger edge, and a taken word is replaced one edge after the handshake. The bench therefore drives inputs on the falling edge and computes the expected timestamp from its own count of edges since reset. It samples one nanosecond after the falling edge and compares words only at handshakes against a queue that the driver filled in the required order. Timing claims such as the closed-period rule, the hold under back-pressure and the absence of words before a trigger are probed at fixed points after the stimulus, where an early or missing word shows up either as an unexpected pop or as a leftover queue entry.

// File: rtl/ts_sorted_readout.sv
module ts_sorted_readout #(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int TS_W     = 8,
  parameter int TICK_DIV = 5,
  parameter int LATENCY  = 60,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ROWS*COLS-1:0] hit_i,
  input  logic                 trig_i,
  input  logic                 trig_mode_i,
  input  logic                 out_ready_i,
  output logic                 out_valid_o,
  output logic [RW-1:0]        out_row_o,
  output logic [CW-1:0]        out_col_o,
  output logic [TS_W-1:0]      out_ts_o
);
  localparam int NPIX = ROWS * COLS;
  localparam int IW   = (NPIX > 1) ? $clog2(NPIX) : 1;
  localparam int DW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DW-1:0]   div_q;
  logic [TS_W-1:0] ts_q;
  logic [NPIX-1:0] occ_q, arm_q;
  logic [TS_W-1:0] pts_q [NPIX];
  logic [TS_W-1:0] age_w [NPIX];

  logic            sel_found;
  logic [IW-1:0]   sel_idx;
  logic [TS_W-1:0] sel_age;

  wire             tick    = (div_q == DW'(TICK_DIV - 1));
  wire [TS_W-1:0]  trig_ts = ts_q - TS_W'(LATENCY);
  wire             take    = out_valid_o && out_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      ts_q  <= '0;
    end else if (tick) begin
      div_q <= '0;
      ts_q  <= ts_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_comb begin
    for (int p = 0; p < NPIX; p++) age_w[p] = ts_q - pts_q[p];
  end

  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    sel_age   = '0;
    for (int p = 0; p < NPIX; p++) begin
      if (occ_q[p] && (trig_mode_i ? arm_q[p] : (age_w[p] != '0)) &&
          (!sel_found || age_w[p] > sel_age)) begin
        sel_found = 1'b1;
        sel_idx   = IW'(p);
        sel_age   = age_w[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
      arm_q <= '0;
      for (int p = 0; p < NPIX; p++) pts_q[p] <= '0;
    end else begin
      for (int p = 0; p < NPIX; p++) begin
        if (occ_q[p]) begin
          if (take && sel_idx == IW'(p)) begin
            occ_q[p] <= 1'b0;
            arm_q[p] <= 1'b0;
          end else if (trig_mode_i && !arm_q[p] && age_w[p] > TS_W'(LATENCY)) begin
            occ_q[p] <= 1'b0;
          end else if (trig_mode_i && trig_i && pts_q[p] == trig_ts) begin
            arm_q[p] <= 1'b1;
          end
        end else if (hit_i[p]) begin
          occ_q[p] <= 1'b1;
          arm_q[p] <= 1'b0;
          pts_q[p] <= ts_q;
        end
      end
    end
  end

  assign out_valid_o = sel_found;
  assign out_row_o   = RW'(sel_idx / IW'(COLS));
  assign out_col_o   = CW'(sel_idx % IW'(COLS));
  assign out_ts_o    = pts_q[sel_idx];

endmodule

// File: rtl/ts_readout_chk.sv
module ts_readout_chk #(
  parameter int TS_W    = 8,
  parameter int LATENCY = 60,
  parameter int RW      = 3,
  parameter int CW      = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            trig_mode_i,
  input logic            out_ready_i,
  input logic            out_valid_o,
  input logic [RW-1:0]   out_row_o,
  input logic [CW-1:0]   out_col_o,
  input logic [TS_W-1:0] out_ts_o,
  input logic [TS_W-1:0] ts_q
);
  wire [TS_W-1:0] cur_age = ts_q - out_ts_o;

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid_o); // R1

  AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ts_q == $past(ts_q) || ts_q == TS_W'($past(ts_q) + 1'b1))); // R2

  AST_AGE_ORDER: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && out_ready_i |=> !out_valid_o || (cur_age <= TS_W'(ts_q - $past(out_ts_o)))); // R4

  AST_PUSH_CLOSED: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && !trig_mode_i |-> out_ts_o != ts_q); // R6

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_row_o) && $stable(out_col_o) && $stable(out_ts_o)); // R7

  AST_TRIG_AGE: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && trig_mode_i |-> cur_age >= TS_W'(LATENCY)); // R10

endmodule

bind ts_sorted_readout ts_readout_chk #(.TS_W(TS_W), .LATENCY(LATENCY), .RW(RW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .trig_mode_i(trig_mode_i), .out_ready_i(out_ready_i),
  .out_valid_o(out_valid_o), .out_row_o(out_row_o), .out_col_o(out_col_o),
  .out_ts_o(out_ts_o), .ts_q(ts_q)
);

// File: tb/tb_ts_sorted_readout.sv
`timescale 1ns/1ps
module tb_ts_sorted_readout;
  localparam int ROWS = 8, COLS = 8, NPIX = 64, TS_W = 8, TICK_DIV = 5, LATENCY = 60;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst = 1'b1;
  logic [NPIX-1:0] hit = '0;
  logic            trig = 1'b0, mode = 1'b0, ready = 1'b0;
  logic            valid;
  logic [2:0]      row, col;
  logic [TS_W-1:0] ts;

  ts_sorted_readout dut (
    .clk(clk), .rst(rst), .hit_i(hit), .trig_i(trig), .trig_mode_i(mode),
    .out_ready_i(ready), .out_valid_o(valid), .out_row_o(row), .out_col_o(col), .out_ts_o(ts)
  );

  int n_edges = 0;
  int checks = 0, fails = 0;
  int q[$];
  bit done = 0;

  always @(posedge clk) begin
    if (rst) n_edges <= 0;
    else     n_edges <= n_edges + 1;
  end

  function automatic int ts_next();
    return (n_edges / TICK_DIV) % 256;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (!rst && valid && ready) begin
      int act;
      act = (int'(row) * COLS + int'(col)) * 1024 + int'(ts);
      if (q.size() == 0) check(1'b0, "R9/R10 unexpected word", act, -1);
      else begin
        int exp;
        exp = q.pop_front();
        check(act == exp, "R3/R4/R5 word idx*1024+ts", act, exp);
      end
    end
  end

  task automatic tick_start();
    @(negedge clk);
    while (n_edges % TICK_DIV != 0) @(negedge clk);
  endtask

  task automatic wait_ts(input int t);
    @(negedge clk);
    while (!(ts_next() == (t % 256) && n_edges % TICK_DIV == 0)) @(negedge clk);
  endtask

  task automatic hit_group(input logic [NPIX-1:0] drive, input logic [NPIX-1:0] expect_m);
    int t;
    t = ts_next();
    hit = drive;
    for (int i = 0; i < NPIX; i++) if (expect_m[i]) q.push_back(i * 1024 + t);
    @(negedge clk);
    hit = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NPIX-1:0] m;
    int snap, t0, tc;
    repeat (3) @(negedge clk);
    #1 check(valid == 1'b0, "R1 valid in reset", valid, 0);
    @(negedge clk);
    rst = 1'b0;
    #1 check(valid == 1'b0, "R1 valid after reset", valid, 0);

    // R3 R6 R9: single hit, push mode
    ready = 1'b1;
    tick_start();
    m = '0; m[9] = 1'b1;
    hit_group(m, m);
    #1 check(valid == 1'b0, "R6 word before period closed", valid, 0);
    repeat (10) @(negedge clk);
    check(q.size() == 0, "R9 pending after single hit", q.size(), 0);

    // R4 R5 R7: several ticks, back-pressure
    ready = 1'b0;
    tick_start();
    m = '0; m[45] = 1'b1; m[3] = 1'b1; m[17] = 1'b1;
    hit_group(m, m);
    tick_start();
    m = '0; m[40] = 1'b1; m[2] = 1'b1;
    hit_group(m, m);
    tick_start();
    m = '0; m[63] = 1'b1;
    hit_group(m, m);
    repeat (7) @(negedge clk);
    #1 snap = (int'(row) * COLS + int'(col)) * 1024 + int'(ts);
    check(valid == 1'b1, "R7 valid under back-pressure", valid, 1);
    check(snap == q[0], "R5 first word lowest row/col", snap, q[0]);
    repeat (4) @(negedge clk);
    #1 check(((int'(row) * COLS + int'(col)) * 1024 + int'(ts)) == snap && valid,
             "R7 word held", (int'(row) * COLS + int'(col)) * 1024 + int'(ts), snap);
    ready = 1'b1;
    repeat (20) @(negedge clk);
    check(q.size() == 0, "R4 pending after drain", q.size(), 0);

    // R8: dead time on occupied pixel
    ready = 1'b0;
    tick_start();
    m = '0; m[5] = 1'b1;
    hit_group(m, m);
    tick_start();
    m = '0; m[5] = 1'b1; m[6] = 1'b1;
    begin
      logic [NPIX-1:0] e;
      e = '0; e[6] = 1'b1;
      hit_group(m, e);
    end
    repeat (8) @(negedge clk);
    ready = 1'b1;
    repeat (15) @(negedge clk);
    check(q.size() == 0, "R8 pending after dead-time drain", q.size(), 0);
    #1 check(valid == 1'b0, "R8 second hit dropped", valid, 0);

    // R2: wrap of the timestamp
    @(negedge clk);
    ready = 1'b0;
    wait_ts(254);
    m = '0; m[30] = 1'b1;
    hit_group(m, m);
    tick_start();
    m = '0; m[12] = 1'b1;
    hit_group(m, m);
    tick_start();
    check(ts_next() == 0, "R2 bench ts wrapped", ts_next(), 0);
    m = '0; m[1] = 1'b1;
    hit_group(m, m);
    repeat (7) @(negedge clk);
    ready = 1'b1;
    repeat (15) @(negedge clk);
    check(q.size() == 0, "R2 pending after wrap drain", q.size(), 0);

    // R10 R11: triggered mode
    mode = 1'b1;
    tick_start();
    t0 = ts_next();
    m = '0; m[10] = 1'b1;
    hit_group(m, '0);
    tick_start();
    m = '0; m[20] = 1'b1;
    hit_group(m, '0);
    tick_start();
    m = '0; m[10] = 1'b1;
    hit_group(m, '0);
    repeat (12) @(negedge clk);
    #1 check(valid == 1'b0, "R10 no word before trigger", valid, 0);
    wait_ts(t0 + LATENCY);
    trig = 1'b1;
    q.push_back(10 * 1024 + t0);
    @(negedge clk);
    trig = 1'b0;
    repeat (10) @(negedge clk);
    check(q.size() == 0, "R10 triggered hit delivered", q.size(), 0);
    wait_ts(t0 + LATENCY + 3);
    tc = ts_next();
    m = '0; m[20] = 1'b1;
    hit_group(m, '0);
    wait_ts(tc + LATENCY);
    trig = 1'b1;
    q.push_back(20 * 1024 + tc);
    @(negedge clk);
    trig = 1'b0;
    repeat (10) @(negedge clk);
    check(q.size() == 0, "R11 expired pixel reused", q.size(), 0);
    #1 check(valid == 1'b0, "R11 untriggered hit discarded", valid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule